// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives framed asynchronous characters from a single serial data line. A frame has one start bit, eight data bits sent least significant bit first, and one stop bit. Received characters go into a four-entry receive queue. Each entry holds the data byte and a framing-error flag. The block also watches for a line break, and it can gate itself from a carrier-detect pin. Parity, the transmit path and processor bus decoding are not part of this block.

Sampling is paced by a bit-clock enable `bit_clk_en`. This enable comes from a baud generator or an external clock pin, and it is high for one system clock per bit-clock tick.

- In divided mode, each bit lasts 16 or 64 ticks, selected by `cfg_div64`. The line passes through a synchronizer, the start bit is confirmed at its middle, and each later bit is sampled once at its centre.
- In 1X mode (`cfg_x1`), every tick samples one bit straight from the line. In this mode the data must be synchronous to the ticks.

A break is reported on `brk_seen` when a character of all zeros with a framing error becomes the oldest entry of the queue. A high (negated) carrier-detect pin can hold the receiver in reset. A rising edge on that pin raises an interrupt in every configuration.

Top module: `uart_brk_rx`

## Requirements
- R1: With `cfg_x1`=0 and `cfg_div64`=0, a frame with 16 ticks per bit is received. The byte appears on `rd_data` (bit 0 is the first data bit on the line) while `rd_valid`=1, with `rd_ferr`=0 when the stop bit is high.
- R2: With `cfg_div64`=1, frames with 64 ticks per bit are received correctly.
- R3: With `cfg_x1`=1, each tick samples `rxd` directly as one whole bit. The start bit is seen on the first tick at which `rxd` is low.
- R4: In divided mode, a low pulse on `rxd` that ends before the middle of a start bit produces no character.
- R5: A stop bit sampled low stores the character with `rd_ferr`=1. After that, a new start is recognised only once `rxd` has returned high.
- R6: The queue holds 4 entries, read in arrival order by asserting `rd_en` while `rd_valid`=1. A character that arrives while the queue is full is dropped and sets `overrun`. `overrun` stays set until `err_clr` is pulsed or the receiver is held in reset.
- R7: With `cfg_brk_en`=1, `brk_seen` goes to 1 when a character with data 0x00 and `rd_ferr`=1 becomes the queue head. With `cfg_brk_en`=0, `brk_seen` stays 0.
- R8: `brk_seen` is cleared by a pulse on `err_clr`, by reset, and by `io_stop`=1. `io_stop` also holds the receiver in reset and empties the queue.
- R9: With `cfg_cd_ignore`=0 and `cd_in`=1, the receiver is held in reset: the queue is emptied, `brk_seen` and `overrun` clear, and incoming frames are ignored.
- R10: With `cfg_cd_ignore`=1, the level of `cd_in` has no effect on reception.
- R11: `cd_sts` follows `cd_in` after the synchronizer. A rising edge of `cd_in` latches an interrupt whatever `cfg_cd_ignore` is, and `err_clr` clears that latch. `irq` is high while `rd_valid`, `overrun` or the edge latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk_en | input | 1 | One-cycle pulse per bit-clock tick |
| rxd | input | 1 | Serial receive line, idle high |
| cd_in | input | 1 | Carrier-detect pin, high = negated |
| cfg_brk_en | input | 1 | Enable break detection |
| cfg_cd_ignore | input | 1 | 1 = carrier-detect pin does not gate the receiver |
| cfg_x1 | input | 1 | 1 = one tick per bit, synchronous data |
| cfg_div64 | input | 1 | Divided mode: 0 = 16 ticks per bit, 1 = 64 |
| err_clr | input | 1 | Pulse: clear break, overrun and edge latch |
| io_stop | input | 1 | Stop mode: hold receiver in reset |
| rd_en | input | 1 | Pop the queue head |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head character data |
| rd_ferr | output | 1 | Head character framing error |
| overrun | output | 1 | Character lost to a full queue |
| brk_seen | output | 1 | Break detected |
| cd_sts | output | 1 | Synchronized carrier-detect level |
| irq | output | 1 | Receiver interrupt request |

## Verification
A character is pushed about two system clocks after the tick that samples the centre of its stop bit. `brk_seen` follows two clocks after the character reaches the queue head. `cd_sts` follows a pin change after two clocks, and the edge latch one clock after that. Control pulses such as `err_clr` and `io_stop` take effect on the next clock.

The driver holds every bit for its full tick count, so each character is already in the queue by the time the driver has finished sending the stop bit. The monitor compares outputs on falling edges only. Status checks wait at least two extra falling edges past the latest cycle in which a result is due.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("uart_brk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_brk_deser.sv
module uart_brk_deser
   import uart_brk_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_LO = 16,
   parameter int DIV_HI = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              tick,
   input  logic              rx_bit,
   input  logic              x1,
   input  logic              div_hi,
   output logic              push,
   output logic [DATA_W-1:0] data,
   output logic              ferr
);

   localparam int CW = $clog2(DIV_HI) + 1;
   localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   if (!is_pow2(DIV_LO) || !is_pow2(DIV_HI) || DIV_LO < 2 || DIV_HI < DIV_LO) begin : g_bad_div
      $error("uart_brk_deser: dividers must be powers of two, 2 <= DIV_LO <= DIV_HI");
   end

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [CW-1:0]     cnt_inc;
   logic [CW-1:0]     ratio;
   logic [CW-1:0]     half;
   logic [IW-1:0]     idx;
   logic [DATA_W-1:0] shreg;
   logic              armed;

   always_comb begin
      if (x1)          ratio = CW'(1);
      else if (div_hi) ratio = CW'(DIV_HI);
      else             ratio = CW'(DIV_LO);
      half    = ratio >> 1;
      cnt_inc = cnt + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || hold) begin
         st    <= RX_IDLE;
         cnt   <= '0;
         idx   <= '0;
         shreg <= '0;
         armed <= 1'b0;
         push  <= 1'b0;
         data  <= '0;
         ferr  <= 1'b0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  if (rx_bit) begin
                     armed <= 1'b1;
                  end else if (armed) begin
                     idx <= '0;
                     if (x1) begin
                        st  <= RX_DATA;
                        cnt <= '0;
                     end else begin
                        st  <= RX_START;
                        cnt <= CW'(1);
                     end
                  end
               end
               RX_START: begin
                  if (cnt_inc == half) begin
                     st  <= rx_bit ? RX_IDLE : RX_DATA;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt_inc;
                  end
               end
               RX_DATA: begin
                  if (cnt_inc == ratio) begin
                     shreg <= {rx_bit, shreg[DATA_W-1:1]};
                     cnt   <= '0;
                     if (idx == IW'(DATA_W - 1)) st <= RX_STOP;
                     else                        idx <= idx + IW'(1);
                  end else begin
                     cnt <= cnt_inc;
                  end
               end
               RX_STOP: begin
                  if (cnt_inc == ratio) begin
                     push  <= 1'b1;
                     data  <= shreg;
                     ferr  <= ~rx_bit;
                     armed <= rx_bit;
                     st    <= RX_IDLE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt_inc;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_brk_fifo.sv
module uart_brk_fifo
   import uart_brk_pkg::*;
#(
   parameter int W     = 9,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [$clog2(DEPTH):0] count
);

   localparam int AW = $clog2(DEPTH);

   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("uart_brk_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic          do_push;
   logic          do_pop;

   assign empty   = (count == '0);
   assign full    = (count == (AW+1)'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + AW'(1);
         if (do_pop)  rptr <= rptr + AW'(1);
         count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
   import uart_brk_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_LO      = 16,
   parameter int DIV_HI      = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk_en,
   input  logic              rxd,
   input  logic              cd_in,
   input  logic              cfg_brk_en,
   input  logic              cfg_cd_ignore,
   input  logic              cfg_x1,
   input  logic              cfg_div64,
   input  logic              err_clr,
   input  logic              io_stop,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_ferr,
   output logic              overrun,
   output logic              brk_seen,
   output logic              cd_sts,
   output logic              irq
);

   localparam int EW = DATA_W + 1;
   localparam int CNTW = $clog2(FIFO_DEPTH) + 1;

   logic              rxd_s;
   logic              cd_s;
   logic              cd_prev;
   logic              cd_edge_lat;
   logic              hold;
   logic              rx_bit;
   logic              ds_push;
   logic [DATA_W-1:0] ds_data;
   logic              ds_ferr;
   logic [EW-1:0]     head;
   logic              q_empty;
   logic              q_full;
   logic [CNTW-1:0]   q_cnt;
   logic              acc_push;
   logic              acc_pop;
   logic              head_arrive;
   logic              head_new;

   uart_brk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rx (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

   uart_brk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cd (
      .clk(clk), .rst_n(rst_n), .d(cd_in), .q(cd_s));

   assign hold   = io_stop | (~cfg_cd_ignore & cd_s);
   assign rx_bit = cfg_x1 ? rxd : rxd_s;

   uart_brk_deser #(.DATA_W(DATA_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_deser (
      .clk(clk), .rst_n(rst_n), .hold(hold), .tick(bit_clk_en), .rx_bit(rx_bit),
      .x1(cfg_x1), .div_hi(cfg_div64), .push(ds_push), .data(ds_data), .ferr(ds_ferr));

   uart_brk_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(hold), .push(ds_push), .din({ds_ferr, ds_data}),
      .pop(rd_en), .dout(head), .empty(q_empty), .full(q_full), .count(q_cnt));

   assign acc_push    = ds_push & ~q_full;
   assign acc_pop     = rd_en & ~q_empty;
   assign head_arrive = (acc_pop & ((q_cnt > CNTW'(1)) | acc_push)) | (acc_push & q_empty);

   always_ff @(posedge clk) begin
      if (!rst_n || hold) begin
         head_new <= 1'b0;
         brk_seen <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         head_new <= head_arrive;
         if (err_clr) begin
            brk_seen <= 1'b0;
            overrun  <= 1'b0;
         end else begin
            if (head_new && cfg_brk_en && !q_empty && head[DATA_W] && head[DATA_W-1:0] == '0)
               brk_seen <= 1'b1;
            if (ds_push && q_full)
               overrun <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cd_prev     <= 1'b1;
         cd_edge_lat <= 1'b0;
      end else begin
         cd_prev <= cd_s;
         if (err_clr)              cd_edge_lat <= 1'b0;
         else if (cd_s && !cd_prev) cd_edge_lat <= 1'b1;
      end
   end

   assign rd_valid = ~q_empty;
   assign rd_data  = head[DATA_W-1:0];
   assign rd_ferr  = head[DATA_W];
   assign cd_sts   = cd_s;
   assign irq      = rd_valid | overrun | cd_edge_lat;

endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_brk_en,
   input logic              cfg_cd_ignore,
   input logic              err_clr,
   input logic              io_stop,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_ferr,
   input logic              overrun,
   input logic              brk_seen,
   input logic              cd_sts,
   input logic              irq
);

   a_r7_brk_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_seen) |-> $past(cfg_brk_en && rd_valid && rd_ferr && rd_data == '0));

   a_r8_clr_drops_brk: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> !brk_seen && !overrun);

   a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      io_stop |=> !brk_seen && !rd_valid);

   a_r9_cd_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_cd_ignore && cd_sts) |=> !rd_valid && !brk_seen);

   a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !err_clr && !io_stop && !(!cfg_cd_ignore && cd_sts)) |=> overrun);

   a_r6_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rd_valid));

   a_r11_cd_edge_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cd_sts) && !err_clr) |=> irq);

endmodule

bind uart_brk_rx uart_brk_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_brk_en(cfg_brk_en), .cfg_cd_ignore(cfg_cd_ignore),
   .err_clr(err_clr), .io_stop(io_stop), .rd_valid(rd_valid), .rd_data(rd_data),
   .rd_ferr(rd_ferr), .overrun(overrun), .brk_seen(brk_seen), .cd_sts(cd_sts), .irq(irq));

// File: tb/sim_uart_brk_rx.sv
module sim_uart_brk_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_clk_en = 1'b0;
   logic       rxd = 1'b1;
   logic       cd_in = 1'b0;
   logic       cfg_brk_en = 1'b1;
   logic       cfg_cd_ignore = 1'b1;
   logic       cfg_x1 = 1'b0;
   logic       cfg_div64 = 1'b0;
   logic       err_clr = 1'b0;
   logic       io_stop = 1'b0;
   logic       rd_en;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       rd_ferr;
   logic       overrun;
   logic       brk_seen;
   logic       cd_sts;
   logic       irq;

   logic       mon_en = 1'b0;
   logic       mon_rd = 1'b0;
   logic       man_rd = 1'b0;
   logic [8:0] expq[$];
   int         n_chk = 0;
   int         n_fail = 0;
   int         tick_div = 0;

   assign rd_en = mon_rd | man_rd;

   always #10 clk = ~clk;

   uart_brk_rx u0 (
      .clk(clk), .rst_n(rst_n), .bit_clk_en(bit_clk_en), .rxd(rxd), .cd_in(cd_in),
      .cfg_brk_en(cfg_brk_en), .cfg_cd_ignore(cfg_cd_ignore), .cfg_x1(cfg_x1),
      .cfg_div64(cfg_div64), .err_clr(err_clr), .io_stop(io_stop), .rd_en(rd_en),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_ferr(rd_ferr), .overrun(overrun),
      .brk_seen(brk_seen), .cd_sts(cd_sts), .irq(irq));

   always @(negedge clk) begin
      tick_div   <= (tick_div == 3) ? 0 : tick_div + 1;
      bit_clk_en <= (tick_div == 3);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      mon_rd = 1'b0;
      if (mon_en && rd_valid) begin
         if (expq.size() == 0) begin
            check("R1 unexpected char", {23'd0, rd_ferr, rd_data}, 32'h1ff);
         end else begin
            check("R1/R6 char order", {23'd0, rd_ferr, rd_data}, {23'd0, expq.pop_front()});
         end
         mon_rd = 1'b1;
      end
   end

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!bit_clk_en) @(posedge clk);
      end
      #1;
   endtask

   task automatic send(input logic [7:0] d, input logic stopb, input int ratio, input bit expect_it);
      if (expect_it) expq.push_back({stopb ? 1'b0 : 1'b1, d});
      wait_ticks(1);
      rxd = 1'b0;
      wait_ticks(ratio);
      for (int b = 0; b < 8; b++) begin
         rxd = d[b];
         wait_ticks(ratio);
      end
      rxd = stopb;
      wait_ticks(ratio);
      rxd = 1'b1;
      wait_ticks((ratio < 4) ? 4 : ratio);
   endtask

   task automatic pop_chk(input string req, input logic [8:0] exp);
      @(negedge clk);
      check(req, {22'd0, rd_valid, rd_ferr, rd_data}, {22'd0, 1'b1, exp});
      man_rd = 1'b1;
      @(negedge clk);
      man_rd = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 reset brk", {31'd0, brk_seen}, 0);
      check("R6 reset empty", {29'd0, rd_valid, overrun, irq}, 0);

      // R1 / R2 / R3 / R5: stream through scoreboard
      mon_en = 1'b1;
      send(8'hA5, 1'b1, 16, 1);
      send(8'h3C, 1'b1, 16, 1);
      send(8'h01, 1'b1, 16, 1);
      cfg_div64 = 1'b1;
      send(8'h5A, 1'b1, 64, 1);   // R2
      send(8'hFF, 1'b1, 64, 1);
      cfg_div64 = 1'b0;
      cfg_x1 = 1'b1;
      send(8'h96, 1'b1, 1, 1);    // R3
      send(8'h00, 1'b1, 1, 1);
      cfg_x1 = 1'b0;
      send(8'h7E, 1'b0, 16, 1);   // R5 framing error
      check("R7 nonzero ferr no brk", {31'd0, brk_seen}, 0);
      send(8'hC3, 1'b1, 16, 1);   // R5 recovery after line high

      // R4: short start glitch
      wait_ticks(2);
      rxd = 1'b0;
      wait_ticks(4);
      rxd = 1'b1;
      wait_ticks(200);
      check("R4 glitch ignored", {31'd0, rd_valid}, 0);
      check("R1 queue drained", expq.size(), 0);

      // R6: overrun
      mon_en = 1'b0;
      for (int k = 1; k <= 5; k++) send(8'(k * 17), 1'b1, 16, k <= 4);
      check("R6 overrun set", {31'd0, overrun}, 1);
      check("R11 irq on overrun", {31'd0, irq}, 1);
      mon_en = 1'b1;
      repeat (10) @(negedge clk);
      check("R6 four kept", expq.size(), 0);
      check("R6 overrun sticky", {31'd0, overrun}, 1);
      mon_en = 1'b0;
      pulse_clr();
      check("R6 overrun cleared", {30'd0, overrun, irq}, 0);

      // R7 / R8: break
      send(8'h00, 1'b0, 16, 0);
      repeat (3) @(negedge clk);
      check("R7 brk set", {31'd0, brk_seen}, 1);
      pulse_clr();
      check("R8 err_clr clears brk", {31'd0, brk_seen}, 0);
      pop_chk("R7 brk char stored", 9'h100);
      cfg_brk_en = 1'b0;
      send(8'h00, 1'b0, 16, 0);
      repeat (3) @(negedge clk);
      check("R7 brk disabled", {31'd0, brk_seen}, 0);
      pop_chk("R7 brk char kept", 9'h100);
      cfg_brk_en = 1'b1;
      send(8'h00, 1'b0, 16, 0);
      repeat (3) @(negedge clk);
      check("R7 brk set again", {31'd0, brk_seen}, 1);
      @(negedge clk);
      io_stop = 1'b1;
      @(negedge clk);
      io_stop = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 io_stop clears", {30'd0, brk_seen, rd_valid}, 0);

      // R11 / R10: carrier detect ignored but edge visible
      cd_in = 1'b1;
      repeat (4) @(negedge clk);
      check("R11 cd_sts", {31'd0, cd_sts}, 1);
      check("R11 edge irq", {31'd0, irq}, 1);
      pulse_clr();
      check("R11 edge latch cleared", {31'd0, irq}, 0);
      send(8'h42, 1'b1, 16, 0);
      repeat (2) @(negedge clk);
      check("R10 cd ignored", {22'd0, rd_valid, rd_ferr, rd_data}, {22'd0, 10'h242});

      // R9: auto-enable holds receiver
      cfg_cd_ignore = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 flush on hold", {31'd0, rd_valid}, 0);
      send(8'h24, 1'b1, 16, 0);
      check("R9 frame ignored", {30'd0, rd_valid, irq}, 0);
      cd_in = 1'b0;
      repeat (4) @(negedge clk);
      check("R11 cd_sts low", {31'd0, cd_sts}, 0);
      mon_en = 1'b1;
      send(8'h81, 1'b1, 16, 1);
      repeat (4) @(negedge clk);
      check("R9 resumes", expq.size(), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule